// File: doc/BRIEF.md
# Four-Channel Serial Status and Pin Combiner

This block holds the global control and status state that four serial transfer channels share. Each channel reports the start and the end of a transfer with single-cycle strobes. The block keeps a busy bit and a completion flag for every channel. It drives one interrupt line, which is the OR over all channels of each flag gated by that channel's enable. It also merges the frame, clock and data outputs of the selected channels onto one shared group of three pins.

Software reaches the state through one 32-bit register port. A write loads the output-select and interrupt-enable fields and clears completion flags: a 1 clears a flag, a 0 leaves it alone. The busy field is read-only. When several channels are selected at once, their outputs are ORed together. The merge does not pick a single channel.

Top module: `sstat_combiner`

## Requirements
- R1: After a synchronous active-low reset, the whole read word is 0, `irq` is 0 and all three shared pins are 0.
- R2: A write loads bits [15:12] as output selects (bit 12+n for channel n) and bits [11:8] as interrupt enables (bit 8+n for channel n). Both fields read back at the same positions from the cycle after the write.
- R3: Busy bit n is read at bit n. A start strobe on channel n sets it at the next clock edge. A done strobe clears it at the next edge. If start and done arrive in the same cycle, the bit ends up 1.
- R4: A done strobe on channel n sets completion flag n, read at bit 4+n, at the next edge. The flag then holds until software clears it.
- R5: Writing 1 to bit 4+n clears flag n at the next edge. Writing 0 there leaves the flag unchanged.
- R6: If a done strobe and a write-1 clear reach the same flag in one cycle, the flag ends up 1.
- R7: `irq` is 1 exactly when some channel has both its flag and its enable at 1. It follows the register state with no added delay.
- R8: Each shared pin (frame, clock, data) is the OR of that signal over all channels whose select bit is 1. With no channel selected, the pin is 0.
- R9: Writes to bits [3:0] and [31:16] have no effect. Bits [31:16] always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ch_start | input | 4 | Per-channel transfer start strobes |
| ch_done | input | 4 | Per-channel transfer done strobes |
| ch_frm | input | 4 | Per-channel frame outputs |
| ch_sck | input | 4 | Per-channel serial clock outputs |
| ch_sdo | input | 4 | Per-channel serial data outputs |
| pin_frm | output | 1 | Shared frame pin |
| pin_sck | output | 1 | Shared serial clock pin |
| pin_sdo | output | 1 | Shared serial data pin |
| irq | output | 1 | Combined interrupt |

## Verification
Two pairs of events can land in the same cycle. A channel's done strobe can meet a software write that clears the same flag, and a done strobe can meet a start strobe on the same channel. The bench drives the write and the strobe on the same falling edge, so both are sampled by one rising edge. It then judges the result by reading the word back after that edge. The flag must read 1 and the busy bit must read 1, while the flags that were cleared without a competing done strobe must read 0.

// File: rtl/sstat_pkg.sv
// Package: shared constants for the serial status combiner.
// Assumes the read word packs four equal-width fields of N_CH bits each,
// lowest field first: busy, flag, enable, select.
package sstat_pkg;
    typedef enum logic [1:0] {
        FLD_BUSY = 2'd0,
        FLD_FLAG = 2'd1,
        FLD_IEN  = 2'd2,
        FLD_SEL  = 2'd3
    } sstat_field_e;

    localparam int unsigned FIELD_COUNT = 4;

    // Lowest bit of a field for a given channel count.
    function automatic int unsigned field_lsb(input sstat_field_e f, input int unsigned n_ch);
        return int'(f) * n_ch;
    endfunction
endpackage

// File: rtl/sstat_chan.sv
// Module: per-channel busy and completion-flag state.
// Busy sets on start and clears on done, with start winning a tie.
// The flag sets on done and clears on a software clear, with done winning a tie.
// Assumes strobes are single-cycle and synchronous to clk.
module sstat_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    input  logic clr,
    output logic busy,
    output logic flag
);
    // Busy tracking: a start takes priority over a done in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     busy <= 1'b0;
        else if (start) busy <= 1'b1;
        else if (done)  busy <= 1'b0;
    end

    // Completion flag: a done takes priority over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (done) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    p_start_sets_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    p_done_clears_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !busy);
    p_done_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> flag);
    p_flag_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !clr) |=> $stable(flag));
    p_clear_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !done) |=> !flag);
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && done) |=> flag);
endmodule

// File: rtl/sstat_ctrl_reg.sv
// Module: software-written output-select and interrupt-enable fields.
// Assumes the top has already extracted the fields from the write word.
module sstat_ctrl_reg #(
    parameter int unsigned N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [N_CH-1:0] wr_sel,
    input  logic [N_CH-1:0] wr_ien,
    output logic [N_CH-1:0] sel,
    output logic [N_CH-1:0] ien
);
    // Load both fields on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= '0;
            ien <= '0;
        end else if (wr) begin
            sel <= wr_sel;
            ien <= wr_ien;
        end
    end

    p_sel_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (sel == $past(wr_sel)));
    p_ien_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (ien == $past(wr_ien)));
    p_ctrl_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(sel) && $stable(ien)));
endmodule

// File: rtl/sstat_pin_merge.sv
// Module: wired-OR merge of the selected channels onto shared pins.
// Each of the N_SIG signal groups produces one pin. Purely combinational.
module sstat_pin_merge #(
    parameter int unsigned N_CH  = 4,
    parameter int unsigned N_SIG = 3
) (
    input  logic [N_CH-1:0]            sel,
    input  logic [N_SIG-1:0][N_CH-1:0] sig_in,
    output logic [N_SIG-1:0]           pin_out
);
    for (genvar s = 0; s < N_SIG; s++) begin : g_sig
        // OR every selected channel's copy of signal s.
        always_comb pin_out[s] = |(sig_in[s] & sel);
    end
endmodule

// File: rtl/sstat_combiner.sv
// Module: top of the serial status and pin combiner.
// It holds the register word, instantiates the per-channel state, raises the
// combined interrupt and merges the selected channel outputs onto the pins.
// Assumes 4*N_CH <= DATA_W. Reads are combinational and have no side effects.
module sstat_combiner
    import sstat_pkg::*;
#(
    parameter int unsigned N_CH   = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_CH-1:0]   ch_start,
    input  logic [N_CH-1:0]   ch_done,
    input  logic [N_CH-1:0]   ch_frm,
    input  logic [N_CH-1:0]   ch_sck,
    input  logic [N_CH-1:0]   ch_sdo,
    output logic              pin_frm,
    output logic              pin_sck,
    output logic              pin_sdo,
    output logic              irq
);
    localparam int unsigned BUSY_LSB = field_lsb(FLD_BUSY, N_CH);
    localparam int unsigned FLAG_LSB = field_lsb(FLD_FLAG, N_CH);
    localparam int unsigned IEN_LSB  = field_lsb(FLD_IEN, N_CH);
    localparam int unsigned SEL_LSB  = field_lsb(FLD_SEL, N_CH);
    localparam int unsigned USED_W   = FIELD_COUNT * N_CH;
    localparam int unsigned N_SIG    = 3;

    logic [N_CH-1:0] busy, flag, sel, ien;
    logic [N_SIG-1:0][N_CH-1:0] sig_bus;
    logic [N_SIG-1:0] pins;

    sstat_ctrl_reg #(.N_CH(N_CH)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .wr_sel (reg_wdata[SEL_LSB +: N_CH]),
        .wr_ien (reg_wdata[IEN_LSB +: N_CH]),
        .sel    (sel),
        .ien    (ien)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        sstat_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .start (ch_start[c]),
            .done  (ch_done[c]),
            .clr   (reg_wr && reg_wdata[FLAG_LSB + c]),
            .busy  (busy[c]),
            .flag  (flag[c])
        );
    end

    // Group the channel outputs by signal kind for the merge.
    always_comb begin
        sig_bus[0] = ch_frm;
        sig_bus[1] = ch_sck;
        sig_bus[2] = ch_sdo;
    end

    sstat_pin_merge #(.N_CH(N_CH), .N_SIG(N_SIG)) u_merge (
        .sel     (sel),
        .sig_in  (sig_bus),
        .pin_out (pins)
    );

    // Drive the shared pins from the merged vector.
    always_comb begin
        pin_frm = pins[0];
        pin_sck = pins[1];
        pin_sdo = pins[2];
    end

    // Combined interrupt from the enabled flags.
    always_comb irq = |(flag & ien);

    // Assemble the read word; unused upper bits read 0.
    always_comb begin
        reg_rdata = '0;
        reg_rdata[BUSY_LSB +: N_CH] = busy;
        reg_rdata[FLAG_LSB +: N_CH] = flag;
        reg_rdata[IEN_LSB  +: N_CH] = ien;
        reg_rdata[SEL_LSB  +: N_CH] = sel;
    end

    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:USED_W] == '0);
    p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag != '0));
    p_busy_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_start == '0 && ch_done == '0) |=> $stable(busy));
endmodule

// File: tb/sstat_combiner_bench.sv
`timescale 1ns/1ps
module sstat_combiner_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  ch_start = '0, ch_done = '0;
    logic [3:0]  ch_frm = '0, ch_sck = '0, ch_sdo = '0;
    logic        pin_frm, pin_sck, pin_sdo, irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sstat_combiner u_sstat_combiner (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ch_start(ch_start), .ch_done(ch_done),
        .ch_frm(ch_frm), .ch_sck(ch_sck), .ch_sdo(ch_sdo),
        .pin_frm(pin_frm), .pin_sck(pin_sck), .pin_sdo(pin_sdo), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write cycle; state is visible at the following falling edge.
    task automatic wr(input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic strobe(input logic [3:0] st, input logic [3:0] dn);
        @(negedge clk); ch_start = st; ch_done = dn;
        @(negedge clk); ch_start = '0; ch_done = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 pins/irq", {28'h0, pin_frm, pin_sck, pin_sdo, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 sweep of select and enable fields
        for (int v = 0; v < 256; v++) begin
            wr(32'(v) << 8);
            chk("R2 sel/ien readback", reg_rdata & 32'h0000_FF00, 32'(v) << 8);
        end

        // R9 reserved and busy bits ignored on write
        wr(32'hFFFF_000F);
        chk("R9 reserved/busy write", reg_rdata, 32'h0);

        // R3 busy set, clear and tie
        for (int c = 0; c < 4; c++) begin
            strobe(4'(1 << c), 4'h0);
            chk("R3 busy set", reg_rdata & 32'hF, 32'(1 << c));
            wr(32'h0000_000F ^ 32'h0);
            chk("R9 busy write ignored", reg_rdata & 32'hF, 32'(1 << c));
            strobe(4'h0, 4'(1 << c));
            chk("R3 busy clear", reg_rdata & 32'hF, 32'h0);
            chk("R4 flag set", reg_rdata & 32'hF0, 32'(1 << (c + 4)));
            wr(32'h0000_00F0);
        end
        strobe(4'h5, 4'h5);
        chk("R3 start/done tie busy", reg_rdata & 32'hF, 32'h5);
        strobe(4'h0, 4'h5);
        wr(32'h0000_00F0);

        // R5 clear sweep over all write patterns
        for (int w = 0; w < 16; w++) begin
            strobe(4'h0, 4'hF);
            chk("R4 all flags set", reg_rdata & 32'hF0, 32'hF0);
            wr(32'(w) << 4);
            chk("R5 write-1 clear", (reg_rdata >> 4) & 32'hF, 32'(~w & 4'hF));
            repeat (2) @(negedge clk);
            chk("R4 flag holds", (reg_rdata >> 4) & 32'hF, 32'(~w & 4'hF));
            wr(32'h0000_00F0);
        end

        // R6 done and clear in the same cycle
        for (int c = 0; c < 4; c++) begin
            strobe(4'h0, 4'hF);
            @(negedge clk);
            reg_wr = 1'b1; reg_wdata = 32'h0000_00F0; ch_done = 4'(1 << c);
            @(negedge clk);
            reg_wr = 1'b0; reg_wdata = '0; ch_done = '0;
            chk("R6 set wins", (reg_rdata >> 4) & 32'hF, 32'(1 << c));
            wr(32'h0000_00F0);
        end

        // R7 irq over every flag/enable combination
        for (int f = 0; f < 16; f++) begin
            for (int e = 0; e < 16; e++) begin
                wr(32'(e) << 8);
                strobe(4'h0, 4'(f));
                chk("R7 irq", {31'h0, irq}, {31'h0, ((f & e) != 0)});
                wr(32'h0000_00F0);
            end
        end
        chk("R7 irq low after clear", {31'h0, irq}, 32'h0);

        // R8 pin merge sweep
        for (int s = 0; s < 16; s++) begin
            wr(32'(s) << 12);
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    ch_frm = 4'(a); ch_sck = 4'(b); ch_sdo = 4'(a ^ b ^ 5);
                    #1;
                    chk("R8 pins", {29'h0, pin_frm, pin_sck, pin_sdo},
                        {29'h0, ((a & s) != 0), ((b & s) != 0), (((a ^ b ^ 5) & s) != 0)});
                end
            end
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule